// File: doc/BRIEF.md
# Dual-Port Mailbox and Semaphore Bank

This block links two processors, called side A (the application CPU) and side B (the microcontroller). Each side has a plain register port: a request strobe, a write enable, a word address and write data. Read data is registered and comes back on the cycle after the request. Each side also has one interrupt output.

There are four message slots. Each slot holds a payload word and a command word. When one side writes a slot's command word, it posts that slot toward the other side. The slot's pending flag is then set, and it is marked for the receiving side. The receiver sees the flag in its status register and acknowledges it with a write-one-to-clear. Each side's interrupt is the OR of the flags that are pending toward it and enabled in its own mask.

A bank of 32 semaphore bits lets software claim shared resources. A read of a semaphore is an atomic test-and-set. A write of zero releases the semaphore. When both sides touch the same semaphore or slot in the same cycle, side A takes precedence.

Top module: `ipc_mailbox`

Word address map, identical on both sides: 0..3 payload word of slot 0..3; 4..7 command word of slot 0..3; 8 pending status and acknowledge; 9 interrupt enable mask; 32..63 semaphore 0..31. Every other address reads 0.

## Requirements
- R1: After reset, every payload word, command word, pending flag, enable mask and semaphore is 0. Both interrupts are low and both read data outputs are 0.
- R2: Either side can write a payload word (address i) or a command word (address 4+i) of slot i. A read of that address returns the stored word on the read data output one cycle after the request.
- R3: A command write to slot i sets bit i of the other side's status register (address 8). It does not set bit i of the writer's own status register.
- R4: A side's interrupt is high exactly when some slot is pending toward it and that slot's bit is 1 in the side's enable mask (address 9, bit i for slot i). The mask reads back as written.
- R5: When the receiving side writes address 8 with bit i = 1, the flag of slot i is cleared. A write from the sending side, or a write with bit i = 0, leaves the flag set.
- R6: If a new command write to slot i and an acknowledge of slot i happen in the same cycle, the flag stays set toward the new receiver.
- R7: A read of semaphore k (address 32+k) returns 0 in bit 0 and takes the semaphore if it was free. If it was already taken, the read returns 1 and the semaphore is unchanged.
- R8: A write to semaphore k with bit 0 = 0 frees it, whichever side writes. A write with bit 0 = 1 has no effect.
- R9: When both sides access the same semaphore in the same cycle, only side A's access takes effect. Side B's read returns 1, and side B's write is dropped.
- R10: When both sides write the same payload or command word in the same cycle, side A's value is stored. A command collision posts the slot toward side B.
- R11: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write enable (0 = read) |
| a_addr | input | 6 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid the cycle after a read |
| a_irq | output | 1 | Interrupt toward side A |
| b_req | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write enable (0 = read) |
| b_addr | input | 6 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid the cycle after a read |
| b_irq | output | 1 | Interrupt toward side B |

## Verification
The embedded assertions check four properties on every cycle:
- a command write leaves its slot flagged toward the other side;
- a semaphore read leaves the semaphore taken, and an uncontested release frees it;
- the two sides are never both granted the same semaphore;
- an interrupt is never raised while its mask is empty.

Only the bench's scenarios can show the observed values:
- the payload and command read-back;
- that the acknowledge ignores the sender and zero bits;
- that a post wins over a simultaneous acknowledge;
- the precedence of side A in payload and semaphore collisions;
- the zero returned for unmapped addresses.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int N_SLOT = 4,
  parameter int N_SEM  = 32,
  parameter int DW     = 32,
  parameter int AW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int CMD_BASE  = N_SLOT;
  localparam int STAT_ADDR = 2 * N_SLOT;
  localparam int MASK_ADDR = 2 * N_SLOT + 1;
  localparam int SEM_BASE  = 32;

  logic [DW-1:0]     pay_q [N_SLOT];
  logic [DW-1:0]     cmd_q [N_SLOT];
  logic [N_SLOT-1:0] flag_q, to_b_q, mask_a_q, mask_b_q;
  logic [N_SEM-1:0]  sem_q;
  logic [DW-1:0]     a_rnext, b_rnext;

  wire a_wr = a_req & a_we;
  wire b_wr = b_req & b_we;
  wire a_rd = a_req & ~a_we;
  wire b_rd = b_req & ~b_we;

  wire [N_SLOT-1:0] pend_a = flag_q & ~to_b_q;
  wire [N_SLOT-1:0] pend_b = flag_q & to_b_q;

  assign a_irq = |(pend_a & mask_a_q);
  assign b_irq = |(pend_b & mask_b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      to_b_q   <= '0;
      mask_a_q <= '0;
      mask_b_q <= '0;
      for (int i = 0; i < N_SLOT; i++) begin
        pay_q[i] <= '0;
        cmd_q[i] <= '0;
      end
    end else begin
      if (a_wr && a_addr == AW'(MASK_ADDR)) mask_a_q <= a_wdata[N_SLOT-1:0];
      if (b_wr && b_addr == AW'(MASK_ADDR)) mask_b_q <= b_wdata[N_SLOT-1:0];
      for (int i = 0; i < N_SLOT; i++) begin
        if (a_wr && a_addr == AW'(i))      pay_q[i] <= a_wdata;
        else if (b_wr && b_addr == AW'(i)) pay_q[i] <= b_wdata;
        if (a_wr && a_addr == AW'(CMD_BASE + i)) begin
          cmd_q[i]  <= a_wdata;
          flag_q[i] <= 1'b1;
          to_b_q[i] <= 1'b1;
        end else if (b_wr && b_addr == AW'(CMD_BASE + i)) begin
          cmd_q[i]  <= b_wdata;
          flag_q[i] <= 1'b1;
          to_b_q[i] <= 1'b0;
        end else if ((a_wr && a_addr == AW'(STAT_ADDR) && a_wdata[i] && !to_b_q[i]) ||
                     (b_wr && b_addr == AW'(STAT_ADDR) && b_wdata[i] &&  to_b_q[i])) begin
          flag_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar k = 0; k < N_SEM; k++) begin : g_sem
    wire a_hit = a_req && a_addr == AW'(SEM_BASE + k);
    wire b_hit = b_req && b_addr == AW'(SEM_BASE + k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sem_q[k] <= 1'b0;
      else if (a_hit && !a_we)     sem_q[k] <= 1'b1;
      else if (a_hit)              sem_q[k] <= sem_q[k] & a_wdata[0];
      else if (b_hit && !b_we)     sem_q[k] <= 1'b1;
      else if (b_hit)              sem_q[k] <= sem_q[k] & b_wdata[0];
    end

    assert_sem_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hit && !a_we) |=> sem_q[k]);
    assert_sem_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (b_hit && b_we && !b_wdata[0] && !a_hit) |=> !sem_q[k]);
    assert_sem_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hit && b_hit && !a_we && !b_we) |=> (a_rdata[0] || b_rdata[0]));
  end

  always_comb begin
    a_rnext = '0;
    b_rnext = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (a_addr == AW'(i))            a_rnext = pay_q[i];
      if (a_addr == AW'(CMD_BASE + i)) a_rnext = cmd_q[i];
      if (b_addr == AW'(i))            b_rnext = pay_q[i];
      if (b_addr == AW'(CMD_BASE + i)) b_rnext = cmd_q[i];
    end
    if (a_addr == AW'(STAT_ADDR)) a_rnext[N_SLOT-1:0] = pend_a;
    if (a_addr == AW'(MASK_ADDR)) a_rnext[N_SLOT-1:0] = mask_a_q;
    if (b_addr == AW'(STAT_ADDR)) b_rnext[N_SLOT-1:0] = pend_b;
    if (b_addr == AW'(MASK_ADDR)) b_rnext[N_SLOT-1:0] = mask_b_q;
    for (int k = 0; k < N_SEM; k++) begin
      if (a_addr == AW'(SEM_BASE + k)) a_rnext[0] = sem_q[k];
      if (b_addr == AW'(SEM_BASE + k))
        b_rnext[0] = sem_q[k] | (a_req && a_addr == b_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= a_rnext;
      if (b_rd) b_rdata <= b_rnext;
    end
  end

  for (genvar i = 0; i < N_SLOT; i++) begin : g_chk
    assert_post_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_addr == AW'(CMD_BASE + i)) |=> (flag_q[i] && to_b_q[i]));
    assert_post_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (b_wr && b_addr == AW'(CMD_BASE + i) && !(a_wr && a_addr == AW'(CMD_BASE + i)))
        |=> (flag_q[i] && !to_b_q[i]));
  end

  assert_irq_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_irq |-> (mask_a_q != '0)) and (b_irq |-> (mask_b_q != '0)));
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [5:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk, .rst_n, .a_req, .a_we, .a_addr, .a_wdata, .a_rdata, .a_irq,
    .b_req, .b_we, .b_addr, .b_wdata, .b_rdata, .b_irq);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access2(input logic ar, input logic aw, input logic [5:0] aa, input logic [31:0] ad,
                         input logic br, input logic bw, input logic [5:0] ba, input logic [31:0] bd,
                         output logic [31:0] aq, output logic [31:0] bq);
    @(negedge clk);
    a_req = ar; a_we = aw; a_addr = aa; a_wdata = ad;
    b_req = br; b_we = bw; b_addr = ba; b_wdata = bd;
    @(negedge clk);
    a_req = 0; b_req = 0;
    aq = a_rdata; bq = b_rdata;
  endtask

  task automatic wr(input bit side_b, input logic [5:0] ad, input logic [31:0] d);
    logic [31:0] x, y;
    if (side_b) access2(0, 0, 0, 0, 1, 1, ad, d, x, y);
    else        access2(1, 1, ad, d, 0, 0, 0, 0, x, y);
  endtask

  task automatic rd(input bit side_b, input logic [5:0] ad, output logic [31:0] q);
    logic [31:0] x, y;
    if (side_b) begin access2(0, 0, 0, 0, 1, 0, ad, 0, x, y); q = y; end
    else        begin access2(1, 0, ad, 0, 0, 0, 0, 0, x, y); q = x; end
  endtask

  task automatic t_reset();
    logic [31:0] q;
    check("R1 a_rdata", a_rdata, 0);
    check("R1 b_rdata", b_rdata, 0);
    check("R1 a_irq", a_irq, 0);
    check("R1 b_irq", b_irq, 0);
    rd(0, 8, q);  check("R1 status", q, 0);
    rd(1, 9, q);  check("R1 mask", q, 0);
    rd(0, 6, q);  check("R1 cmd", q, 0);
  endtask

  task automatic t_words();
    logic [31:0] q;
    wr(0, 2, 32'hCAFE_0102);
    rd(1, 2, q); check("R2 payload A->B", q, 32'hCAFE_0102);
    wr(1, 3, 32'h5555_AAAA);
    rd(0, 3, q); check("R2 payload B->A", q, 32'h5555_AAAA);
  endtask

  task automatic t_post();
    logic [31:0] q;
    wr(0, 4, 32'h11);
    rd(1, 4, q); check("R2 cmd readback", q, 32'h11);
    rd(1, 8, q); check("R3 receiver status", q, 32'h1);
    rd(0, 8, q); check("R3 sender status", q, 32'h0);
    check("R4 masked irq", b_irq, 0);
    wr(1, 9, 32'h1);
    check("R4 enabled irq", b_irq, 1);
    rd(1, 9, q); check("R4 mask readback", q, 32'h1);
    wr(0, 8, 32'hF);
    rd(1, 8, q); check("R5 sender ack ignored", q, 32'h1);
    wr(1, 8, 32'h2);
    rd(1, 8, q); check("R5 zero bit ignored", q, 32'h1);
    wr(1, 8, 32'h1);
    rd(1, 8, q); check("R5 ack clears", q, 32'h0);
    check("R5 irq drops", b_irq, 0);
    wr(1, 7, 32'h77);
    check("R4 irq A masked", a_irq, 0);
    wr(0, 9, 32'h8);
    check("R4 irq A enabled", a_irq, 1);
    wr(0, 8, 32'h8);
    check("R5 irq A drops", a_irq, 0);
  endtask

  task automatic t_race();
    logic [31:0] x, y, q;
    wr(1, 6, 32'h1);
    access2(1, 1, 8, 32'h4, 1, 1, 6, 32'h2, x, y);
    rd(0, 8, q); check("R6 post beats ack", q, 32'h4);
    wr(0, 8, 32'h4);
    rd(0, 8, q); check("R6 cleared after", q, 32'h0);
  endtask

  task automatic t_sem();
    logic [31:0] q;
    rd(0, 37, q); check("R7 take free", q, 0);
    rd(1, 37, q); check("R7 taken by other", q, 1);
    rd(0, 37, q); check("R7 taken by self", q, 1);
    wr(1, 37, 32'h1);
    rd(0, 37, q); check("R8 write one ignored", q, 1);
    wr(1, 37, 32'h0);
    rd(1, 37, q); check("R8 release then take", q, 0);
    wr(0, 37, 32'h0);
  endtask

  task automatic t_clash();
    logic [31:0] x, y, q;
    access2(1, 0, 41, 0, 1, 0, 41, 0, x, y);
    check("R9 A wins read", x, 0);
    check("R9 B loses read", y, 1);
    access2(1, 0, 41, 0, 1, 1, 41, 0, x, y);
    check("R9 A read while B frees", x, 1);
    rd(1, 41, q); check("R9 B release dropped", q, 1);
    wr(0, 41, 0);
    rd(1, 41, q); check("R9 free after A release", q, 0);
    wr(1, 41, 0);
    access2(1, 1, 1, 32'hAAAA_0001, 1, 1, 1, 32'hBBBB_0001, x, y);
    rd(1, 1, q); check("R10 payload A wins", q, 32'hAAAA_0001);
    access2(1, 1, 4, 32'hA4, 1, 1, 4, 32'hB4, x, y);
    rd(0, 4, q); check("R10 cmd A wins", q, 32'hA4);
    rd(1, 8, q); check("R10 posted toward B", q, 32'h1);
    rd(0, 8, q); check("R10 not toward A", q, 32'h0);
    wr(1, 8, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] q;
    rd(0, 10, q); check("R11 addr 10", q, 0);
    rd(1, 20, q); check("R11 addr 20", q, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_words();
    t_post();
    t_race();
    t_sem();
    t_clash();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule